// File: doc/BRIEF.md
# Page-Mode DRAM Command Controller

This controller sits between a simple word-wide request port (valid/ready handshake, one word per transfer) and an asynchronous-style DRAM that takes a multiplexed address. It splits each host address into a row part and a column part and puts them on one shared address bus in turn. A falling row strobe loads the row, and a falling column strobe loads the column. Registered, active-low row strobe, column strobe and write-enable outputs carry the commands.

After an access the row is left open. A later request to the same row is served with a column strobe alone, with the row strobe held low all the while. A request to a different row closes the row, waits out a precharge time, and then opens the new row. A row that sees no requests for a set number of cycles is closed by the controller. A refresh scheduler raises a request once every fixed interval. Each refresh is a row-only strobe cycle through successive rows. A pending refresh blocks new host requests and closes any open row first.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after synchronous reset, the row strobe, column strobe and write enable are high (inactive), `req_ready` is high and `rsp_valid` is low.
- R2: The host address is `{row, col}`, with the row in the upper ROW_W bits. Opening a row drives the row on `dram_addr` as the row strobe falls. The column follows on `dram_addr` as the column strobe falls.
- R3: Each column strobe stays low for exactly T_CAS cycles. While it is low, `dram_addr` and `dram_we_n` do not change. For a write, `dram_we_n` and `dram_dq_oe` are active during the strobe.
- R4: Every accepted request produces a one-cycle `rsp_valid` pulse in the cycle after its column strobe ends. For a read, `rsp_rdata` carries the word stored at that row and column.
- R5: Successive requests to the open row produce no new row strobe: the row strobe stays low and only the column strobe toggles.
- R6: The row strobe stays high for at least T_RP cycles before any fall, including the close caused by a request to a different row.
- R7: The column strobe is never low while the row strobe is high. It falls only after the row strobe has been low for at least T_RCD cycles.
- R8: Refresh is a row-strobe-only cycle with no column strobe. Refreshed rows run 0, 1, 2, … in ascending order and wrap after the last row.
- R9: Under continuous host traffic to one open row, refresh still takes place. The row is closed for it, and the gap between successive refreshes never exceeds REFI plus a few cycles of access and precharge time.
- R10: After IDLE_MAX consecutive cycles of an open row with `req_valid` low, the row strobe returns high. It stays low until then.
- R11: In the cycle after a request is accepted, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address `{row, col}` |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` on reads |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for write data |
| dram_dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The bench attaches a DRAM model that opens a row register on each row-strobe fall and serves or stores words on column strobes. This lets it catch a design that reads from a stale row, or that reopens the row on a page hit (extra activations show up in the count). It separately counts activations for a run of row changes, where a design that skips precharge or shortens it trips the model's timing counters. It checks the idle close one cycle either side of the limit, so an off-by-one timeout fails. It also runs a long stream of page hits, where a design that lets the host starve refresh shows an oversized refresh gap, and the order of refreshed rows is checked throughout.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_OPEN,
    ST_PRE,
    ST_REF
  } fpm_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
  parameter int REFI  = 512,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_take,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CW = (REFI > 2) ? $clog2(REFI) : 1;

  logic [CW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == CW'(REFI - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (ref_take) begin
        ref_pend <= tick;
        ref_row  <= ref_row + 1'b1;
      end else if (tick) begin
        ref_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpm_idle_timer.sv
module fpm_idle_timer #(
  parameter int IDLE_MAX = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  output logic expired
);
  localparam int IW = (IDLE_MAX > 2) ? $clog2(IDLE_MAX) : 1;

  logic [IW-1:0] idle_cnt;

  assign expired = armed && (idle_cnt == IW'(IDLE_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      idle_cnt <= '0;
    end else if (idle_cnt != IW'(IDLE_MAX - 1)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fpm_cmd_seq.sv
module fpm_cmd_seq
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 4,
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_pend,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_take,
  input  logic              idle_expired,
  output logic              row_open,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int TMAX = max2(max2(T_RCD, T_CAS), max2(T_RP, T_RAS));
  localparam int TW   = $clog2(TMAX + 1);

  fpm_state_e        st, st_n;
  logic [TW-1:0]     tmr, tmr_n;
  logic [ROW_W-1:0]  cur_row, open_row, act_row;
  logic [COL_W-1:0]  cur_col, col_sel;
  logic              cur_we, we_sel, acc_pend;
  logic [DATA_W-1:0] cur_wd, wd_sel;
  logic              accept, tmr_done, hit;

  assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign tmr_done  = (tmr == '0);
  assign hit       = (req_row == open_row);
  assign ref_take  = (st == ST_IDLE) && ref_pend;
  assign row_open  = (st == ST_OPEN);

  assign act_row = accept ? req_row   : cur_row;
  assign col_sel = accept ? req_col   : cur_col;
  assign we_sel  = accept ? req_we    : cur_we;
  assign wd_sel  = accept ? req_wdata : cur_wd;

  always_comb begin
    st_n  = st;
    tmr_n = tmr_done ? tmr : tmr - 1'b1;
    case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          st_n  = ST_REF;
          tmr_n = TW'(T_RAS - 1);
        end else if (req_valid) begin
          st_n  = ST_ACT;
          tmr_n = TW'(T_RCD - 1);
        end
      end
      ST_ACT: begin
        if (tmr_done) begin
          st_n  = ST_COL;
          tmr_n = TW'(T_CAS - 1);
        end
      end
      ST_COL: begin
        if (tmr_done) st_n = ST_OPEN;
      end
      ST_OPEN: begin
        if (ref_pend || idle_expired) begin
          st_n  = ST_PRE;
          tmr_n = TW'(T_RP - 1);
        end else if (req_valid) begin
          if (hit) begin
            st_n  = ST_COL;
            tmr_n = TW'(T_CAS - 1);
          end else begin
            st_n  = ST_PRE;
            tmr_n = TW'(T_RP - 1);
          end
        end
      end
      ST_PRE: begin
        if (tmr_done) begin
          if (acc_pend) begin
            st_n  = ST_ACT;
            tmr_n = TW'(T_RCD - 1);
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_REF: begin
        if (tmr_done) begin
          st_n  = ST_PRE;
          tmr_n = TW'(T_RP - 1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      tmr       <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_we    <= 1'b0;
      cur_wd    <= '0;
      acc_pend  <= 1'b0;
      open_row  <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      addr      <= '0;
      dq_out    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st  <= st_n;
      tmr <= tmr_n;
      if (accept) begin
        cur_row <= req_row;
        cur_col <= req_col;
        cur_we  <= req_we;
        cur_wd  <= req_wdata;
      end
      if (accept)             acc_pend <= 1'b1;
      else if (st == ST_COL)  acc_pend <= 1'b0;
      if (st_n == ST_ACT && st != ST_ACT) open_row <= act_row;

      ras_n <= !((st_n == ST_ACT) || (st_n == ST_COL) ||
                 (st_n == ST_OPEN) || (st_n == ST_REF));
      cas_n <= !(st_n == ST_COL);
      we_n  <= !((st_n == ST_COL) && we_sel);
      dq_oe <= (st_n == ST_COL) && we_sel;
      if (st_n == ST_COL) dq_out <= wd_sel;
      if (st_n == ST_ACT && st != ST_ACT) addr <= AW'(act_row);
      else if (st_n == ST_REF && st != ST_REF) addr <= AW'(ref_row);
      else if (st_n == ST_COL && st != ST_COL) addr <= AW'(col_sel);

      rsp_valid <= (st == ST_COL) && tmr_done;
      if ((st == ST_COL) && tmr_done && !cur_we) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W    = 6,
  parameter int COL_W    = 5,
  parameter int DATA_W   = 16,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_RP     = 3,
  parameter int T_RAS    = 4,
  parameter int REFI     = 512,
  parameter int IDLE_MAX = 16,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [AW-1:0]     dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  logic [ROW_W-1:0] req_row, ref_row;
  logic [COL_W-1:0] req_col;
  logic             ref_pend, ref_take, idle_expired, row_open;

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  fpm_refresh_sched #(.REFI(REFI), .ROW_W(ROW_W)) u_ref (
    .clk(clk), .rst(rst), .ref_take(ref_take),
    .ref_pend(ref_pend), .ref_row(ref_row)
  );

  fpm_idle_timer #(.IDLE_MAX(IDLE_MAX)) u_idle (
    .clk(clk), .rst(rst), .armed(row_open && !req_valid),
    .expired(idle_expired)
  );

  fpm_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .ref_pend(ref_pend), .ref_row(ref_row), .ref_take(ref_take),
    .idle_expired(idle_expired), .row_open(row_open),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .addr(dram_addr), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe),
    .dq_in(dram_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int AW    = 6,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          dram_ras_n,
  input logic          dram_cas_n,
  input logic          dram_we_n,
  input logic [AW-1:0] dram_addr
);
  logic [7:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= 8'hFF;
      cas_lo_cnt <= '0;
    end else begin
      ras_lo_cnt <= dram_ras_n ? 8'd0 : ((ras_lo_cnt == 8'hFF) ? ras_lo_cnt : ras_lo_cnt + 8'd1);
      ras_hi_cnt <= !dram_ras_n ? 8'd0 : ((ras_hi_cnt == 8'hFF) ? ras_hi_cnt : ras_hi_cnt + 8'd1);
      cas_lo_cnt <= dram_cas_n ? 8'd0 : ((cas_lo_cnt == 8'hFF) ? cas_lo_cnt : cas_lo_cnt + 8'd1);
    end
  end

  // R7
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R7
  rcd_met_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> (ras_lo_cnt >= 8'(T_RCD)));

  // R6
  precharge_met_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= 8'(T_RP)));

  // R3
  cas_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> (cas_lo_cnt == 8'(T_CAS)));

  // R3
  cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && !$past(dram_cas_n)) |-> ($stable(dram_addr) && $stable(dram_we_n)));

  // R4
  rsp_after_cas_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!$past(dram_cas_n) && dram_cas_n));

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .AW(AW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_addr(dram_addr)
);

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;
  localparam int ROW_W = 6, COL_W = 5, DATA_W = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RAS = 4;
  localparam int REFI = 700, IDLE_MAX = 16;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DATA_W-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [AW-1:0] dram_addr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS), .REFI(REFI), .IDLE_MAX(IDLE_MAX)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // behavioural DRAM with a row register
  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  logic [ROW_W-1:0] model_row = '0, win_row = '0, exp_ref_row = '0;
  logic ras_prev = 1'b1, cas_prev = 1'b1, saw_cas = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic we_prev = 1'b1;
  int hi_cnt = 1000, lo_cnt = 0, cas_w = 0, cyc = 0, last_ref = 0;
  int act_cnt = 0, ref_cnt = 0, max_gap = 0;
  int rp_viol = 0, rcd_viol = 0, cas_err = 0, hold_err = 0, ref_err = 0;
  int vectors = 0, fails = 0;
  bit done = 0;

  assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[{model_row, dram_addr[COL_W-1:0]}] : '0;

  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;

  always @(posedge clk) begin
    if (rst) begin
      ras_prev <= 1'b1; cas_prev <= 1'b1; hi_cnt <= 1000; lo_cnt <= 0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (!dram_ras_n && ras_prev) begin
        if (hi_cnt < T_RP) rp_viol <= rp_viol + 1;
        model_row <= dram_addr[ROW_W-1:0];
        win_row   <= dram_addr[ROW_W-1:0];
        act_cnt   <= act_cnt + 1;
        saw_cas   <= 1'b0;
      end
      if (dram_ras_n && !ras_prev && !saw_cas) begin
        ref_cnt <= ref_cnt + 1;
        if (win_row != exp_ref_row) ref_err <= ref_err + 1;
        exp_ref_row <= win_row + 1'b1;
        if (cyc - last_ref > max_gap) max_gap <= cyc - last_ref;
        last_ref <= cyc;
      end
      hi_cnt <= dram_ras_n ? hi_cnt + 1 : 0;
      lo_cnt <= dram_ras_n ? 0 : lo_cnt + 1;
      if (!dram_cas_n) begin
        saw_cas <= 1'b1;
        if (dram_ras_n) rcd_viol <= rcd_viol + 1;
        if (cas_prev && lo_cnt < T_RCD) rcd_viol <= rcd_viol + 1;
        if (!cas_prev && (dram_addr != addr_prev || dram_we_n != we_prev)) hold_err <= hold_err + 1;
        if (!dram_we_n) mem[{model_row, dram_addr[COL_W-1:0]}] <= dram_dq_out;
      end
      cas_w <= dram_cas_n ? 0 : cas_w + 1;
      if (dram_cas_n && !cas_prev && cas_w != T_CAS) cas_err <= cas_err + 1;
      ras_prev <= dram_ras_n; cas_prev <= dram_cas_n;
      addr_prev <= dram_addr; we_prev <= dram_we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic acc(input logic we, input int row, input int col,
                     input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we;
    req_addr = {row[ROW_W-1:0], col[COL_W-1:0]}; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dram_ras_n == 1, "R1", dram_ras_n, 1);
    chk(dram_cas_n == 1, "R1", dram_cas_n, 1);
    chk(dram_we_n == 1, "R1", dram_we_n, 1);
    chk(req_ready == 1, "R1", req_ready, 1);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);
  endtask

  task automatic t_idle_close();
    logic [DATA_W-1:0] rd;
    int a0 = act_cnt;
    acc(1'b1, 5, 3, 16'h1234, rd);
    chk(act_cnt - a0 == 1, "R2", act_cnt - a0, 1);
    chk(model_row == 6'd5, "R2", model_row, 5);
    repeat (IDLE_MAX - 2) @(negedge clk);
    chk(dram_ras_n == 0, "R10", dram_ras_n, 0);
    repeat (3) @(negedge clk);
    chk(dram_ras_n == 1, "R10", dram_ras_n, 1);
    acc(1'b0, 5, 3, 16'h0, rd);
    chk(rd == 16'h1234, "R4", rd, 16'h1234);
  endtask

  task automatic t_page_hit();
    logic [DATA_W-1:0] rd;
    int a0 = act_cnt;
    for (int c = 0; c < 4; c++) acc(1'b1, 9, c, 16'hA000 + 16'(c), rd);
    for (int c = 0; c < 4; c++) begin
      acc(1'b0, 9, c, 16'h0, rd);
      chk(rd == 16'hA000 + 16'(c), "R4", rd, 16'hA000 + c);
    end
    chk(act_cnt - a0 == 1, "R5", act_cnt - a0, 1);
    chk(dram_ras_n == 0, "R5", dram_ras_n, 0);
  endtask

  task automatic t_page_miss();
    logic [DATA_W-1:0] rd;
    int a0 = act_cnt;
    acc(1'b1, 10, 1, 16'h5A5A, rd);
    acc(1'b1, 11, 1, 16'hC3C3, rd);
    acc(1'b0, 10, 1, 16'h0, rd);
    chk(rd == 16'h5A5A, "R6", rd, 16'h5A5A);
    acc(1'b0, 11, 1, 16'h0, rd);
    chk(rd == 16'hC3C3, "R6", rd, 16'hC3C3);
    chk(act_cnt - a0 == 4, "R6", act_cnt - a0, 4);
    chk(rp_viol == 0, "R6", rp_viol, 0);
  endtask

  task automatic t_refresh_idle();
    int r0 = ref_cnt;
    repeat (3 * REFI) @(negedge clk);
    chk(ref_cnt - r0 >= 3, "R8", ref_cnt - r0, 3);
    chk(ref_err == 0, "R8", ref_err, 0);
  endtask

  task automatic t_refresh_busy();
    logic [DATA_W-1:0] rd;
    int r0 = ref_cnt;
    int stop = cyc + 2 * REFI + 100;
    int k = 0;
    while (cyc < stop) begin
      acc(1'b1, 20, k % 32, 16'(k * 7 + 1), rd);
      acc(1'b0, 20, k % 32, 16'h0, rd);
      chk(rd == 16'(k * 7 + 1), "R9", rd, k * 7 + 1);
      k++;
    end
    chk(ref_cnt - r0 >= 2, "R9", ref_cnt - r0, 2);
    chk(max_gap <= REFI + 20, "R9", max_gap, REFI + 20);
    chk(ref_err == 0, "R8", ref_err, 0);
  endtask

  task automatic t_monitors();
    chk(rcd_viol == 0, "R7", rcd_viol, 0);
    chk(cas_err == 0, "R3", cas_err, 0);
    chk(hold_err == 0, "R3", hold_err, 0);
    chk(rp_viol == 0, "R6", rp_viol, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_idle_close();
    t_page_hit();
    t_page_miss();
    t_refresh_idle();
    t_refresh_busy();
    t_monitors();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
    finish_run();
  end
endmodule